// File: doc/BRIEF.md
# Fractional Multiply Butterfly Datapath

This block is the multiply-and-add core of a signal-processing arithmetic unit. It multiplies two 20-bit operands, interpreted as either two's-complement or unsigned numbers. It widens the 40-bit product to the 48-bit accumulator width and can optionally shift it left by one bit so that fractional operands stay aligned. It then combines the product with a 48-bit addend. A single operation can return the product alone, the product plus the addend, or the product minus the addend. In butterfly mode, two adders run side by side so that the sum and the difference come out in the same operation, which is the core step of a radix-2 FFT butterfly.

Operands enter through a valid/ready handshake and results leave through a second valid/ready handshake after one register stage. The rules for back-pressure are as follows:
- The block takes an operation whenever `in_valid` and `in_ready` are both high.
- `in_ready` is high when the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, every result and flag output holds its value.

Each result carries zero, negative, carry and overflow flags. A sticky overflow bit gathers overflows across many operations until a plain clear input drops it.

Top module: `fmb_butterfly`

## Requirements
- R1: With `in_op` = 2'b00, `out_res0` equals `in_x` times `in_y`, taken modulo 2^48. The 40-bit product is sign-extended when `in_signed` = 1 and zero-extended when `in_signed` = 0.
- R2: When `in_frac` = 1, the extended product is shifted left by one bit before it is used in any result, and bit 0 of the shifted product is 0.
- R3: With `in_op` = 2'b01, `out_res0` is product + `in_acc`. With `in_op` = 2'b10, `out_res0` is product − `in_acc`. Both are taken modulo 2^48.
- R4: With `in_op` = 2'b11 (butterfly), `out_res0` is product + `in_acc`, `out_res1` is product − `in_acc` and `out_dual` = 1. For every other code, `out_res1` = 0, `out_dual` = 0 and `out_carry1` = `out_ovf1` = 0.
- R5: `out_zero` and `out_neg` describe `out_res0`. `out_carry` is the carry out of bit 47 of the add; for a subtract, computed as P + ~A + 1, 1 means no borrow. `out_ovf` is two's-complement overflow. For code 2'b00, carry and overflow are 0. `out_carry1` and `out_ovf1` give the same information for the difference in butterfly mode.
- R6: `sticky_ovf` rises after an accepted operation with `out_ovf` or `out_ovf1` set, and holds until `sticky_clr`. If `sticky_clr` is high in the cycle an operation is accepted, `sticky_ovf` takes that operation's overflow alone.
- R7: An operation accepted at a clock edge shows up with `out_valid` = 1 right after that edge. `out_valid` falls after an edge where `out_ready` = 1 and nothing new was accepted.
- R8: While `out_valid` = 1 and `out_ready` = 0, `in_ready` = 0 and all result outputs hold. When `out_ready` = 1, `in_ready` = 1, and a new operation is accepted in the same cycle the old result drains.
- R9: After reset, `out_valid` = 0, `sticky_ovf` = 0, the results are 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken |
| in_op | input | 2 | 00 product, 01 add, 10 subtract, 11 butterfly |
| in_signed | input | 1 | 1: operands two's-complement; 0: unsigned |
| in_frac | input | 1 | 1: shift product left by one |
| in_x | input | 20 | First multiplicand |
| in_y | input | 20 | Second multiplicand |
| in_acc | input | 48 | Addend |
| sticky_clr | input | 1 | Clear sticky overflow |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_res0 | output | 48 | Primary result (product or sum) |
| out_res1 | output | 48 | Butterfly difference, else 0 |
| out_dual | output | 1 | out_res1 carries a result |
| out_zero | output | 1 | out_res0 is zero |
| out_neg | output | 1 | Bit 47 of out_res0 |
| out_carry | output | 1 | Carry of primary add |
| out_ovf | output | 1 | Signed overflow of primary add |
| out_carry1 | output | 1 | Carry of butterfly difference |
| out_ovf1 | output | 1 | Signed overflow of butterfly difference |
| sticky_ovf | output | 1 | Accumulated overflow |

## Verification
A wrong operand extension or a misplaced fractional shift shows up in the very next result as a wrong upper or lowest bit of `out_res0`, so sweeping every operand sign pattern against an arithmetic model exposes it after one operation. A lane that adds when it should subtract breaks the butterfly difference and its carry in the same result. A sticky bit that is lost, set too early or set too late stays wrong for every following operation until the next clear, so the bench checks `sticky_ovf` after each operation. A broken stall path shows up one edge later as a result that changes or a `in_ready` that is high while the output is blocked.

// File: rtl/fmb_pkg.sv
package fmb_pkg;

  typedef enum logic [1:0] {
    FMB_OP_MUL  = 2'b00,
    FMB_OP_ADD  = 2'b01,
    FMB_OP_SUB  = 2'b10,
    FMB_OP_BFLY = 2'b11
  } fmb_op_e;

  typedef struct packed {
    logic zero;
    logic neg;
    logic carry;
    logic ovf;
  } fmb_flags_t;

endpackage

// File: rtl/fmb_mult.sv
// Multiplier with signed/unsigned operand extension, widening to the
// result width and optional one-bit fractional alignment.
module fmb_mult #(
  parameter int OPW  = 20,
  parameter int RESW = 48
) (
  input  logic [OPW-1:0]  x,
  input  logic [OPW-1:0]  y,
  input  logic            is_signed,
  input  logic            frac,
  output logic [RESW-1:0] prod
);
  localparam int EXTW  = OPW + 1;
  localparam int FULLW = 2 * EXTW;

  logic signed [EXTW-1:0]  xe;
  logic signed [EXTW-1:0]  ye;
  logic signed [FULLW-1:0] full;
  logic [RESW-1:0]         wide;

  // One extra top bit makes both interpretations a single signed multiply.
  assign xe   = {is_signed & x[OPW-1], x};
  assign ye   = {is_signed & y[OPW-1], y};
  assign full = xe * ye;

  generate
    if (RESW > FULLW) begin : g_extend
      assign wide = {{(RESW-FULLW){full[FULLW-1]}}, full};
    end else begin : g_trunc
      assign wide = full[RESW-1:0];
    end
  endgenerate

  assign prod = frac ? {wide[RESW-2:0], 1'b0} : wide;
endmodule

// File: rtl/fmb_addsub.sv
// One adder lane: a + b or a - b with carry and signed overflow.
module fmb_addsub #(
  parameter int W = 48
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] bx;
  logic [W:0]   tot;

  assign bx    = sub ? ~b : b;
  assign tot   = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
  assign res   = tot[W-1:0];
  assign carry = tot[W];
  assign ovf   = (a[W-1] == bx[W-1]) && (tot[W-1] != a[W-1]);
endmodule

// File: rtl/fmb_flagger.sv
// Status flags of one result; carry and overflow only for arithmetic ops.
module fmb_flagger
  import fmb_pkg::*;
#(
  parameter int W = 48
) (
  input  logic [W-1:0] res,
  input  logic         carry,
  input  logic         ovf,
  input  logic         arith,
  output fmb_flags_t   flags
);
  always_comb begin
    flags.zero  = (res == '0);
    flags.neg   = res[W-1];
    flags.carry = arith & carry;
    flags.ovf   = arith & ovf;
  end
endmodule

// File: rtl/fmb_butterfly.sv
// Fractional multiply with add, subtract or butterfly sum/difference,
// one register stage and valid/ready on both sides.
module fmb_butterfly
  import fmb_pkg::*;
#(
  parameter int OPW  = 20,
  parameter int ACCW = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_op,
  input  logic            in_signed,
  input  logic            in_frac,
  input  logic [OPW-1:0]  in_x,
  input  logic [OPW-1:0]  in_y,
  input  logic [ACCW-1:0] in_acc,
  input  logic            sticky_clr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ACCW-1:0] out_res0,
  output logic [ACCW-1:0] out_res1,
  output logic            out_dual,
  output logic            out_zero,
  output logic            out_neg,
  output logic            out_carry,
  output logic            out_ovf,
  output logic            out_carry1,
  output logic            out_ovf1,
  output logic            sticky_ovf
);
  localparam int NLANES = 2;
  localparam int PRODW  = 2 * OPW;

  fmb_op_e         op;
  logic            accept;
  logic [ACCW-1:0] prod;
  logic [ACCW-1:0] lane_res [NLANES];
  logic            lane_c   [NLANES];
  logic            lane_v   [NLANES];
  logic            lane_sub [NLANES];
  logic [ACCW-1:0] res0_n;
  logic [ACCW-1:0] res1_n;
  logic            dual_n;
  logic            arith_n;
  logic            carry1_n;
  logic            ovf1_n;
  logic            any_ovf_n;
  logic [ACCW-1:0] lane_balance;
  fmb_flags_t      flags0_n;
  fmb_flags_t      flags0_q;

  assign op       = fmb_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  fmb_mult #(.OPW(OPW), .RESW(ACCW)) u_mult (
    .x(in_x), .y(in_y), .is_signed(in_signed), .frac(in_frac), .prod(prod)
  );

  // Lane 0 follows the op code; lane 1 always forms the difference.
  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    if (i == 0) begin : g_primary
      assign lane_sub[i] = (op == FMB_OP_SUB);
    end else begin : g_diff
      assign lane_sub[i] = 1'b1;
    end
    fmb_addsub #(.W(ACCW)) u_lane (
      .a(prod), .b(in_acc), .sub(lane_sub[i]),
      .res(lane_res[i]), .carry(lane_c[i]), .ovf(lane_v[i])
    );
  end

  assign arith_n   = (op != FMB_OP_MUL);
  assign dual_n    = (op == FMB_OP_BFLY);
  assign res0_n    = arith_n ? lane_res[0] : prod;
  assign res1_n    = dual_n ? lane_res[1] : '0;
  assign carry1_n  = dual_n & lane_c[1];
  assign ovf1_n    = dual_n & lane_v[1];

  fmb_flagger #(.W(ACCW)) u_flags0 (
    .res(res0_n), .carry(lane_c[0]), .ovf(lane_v[0]),
    .arith(arith_n), .flags(flags0_n)
  );

  assign any_ovf_n = flags0_n.ovf | ovf1_n;

  // Output register stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_res0   <= '0;
      out_res1   <= '0;
      out_dual   <= 1'b0;
      flags0_q   <= '0;
      out_carry1 <= 1'b0;
      out_ovf1   <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_res0   <= res0_n;
      out_res1   <= res1_n;
      out_dual   <= dual_n;
      flags0_q   <= flags0_n;
      out_carry1 <= carry1_n;
      out_ovf1   <= ovf1_n;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assign out_zero  = flags0_q.zero;
  assign out_neg   = flags0_q.neg;
  assign out_carry = flags0_q.carry;
  assign out_ovf   = flags0_q.ovf;

  // Sticky overflow: a clear drops history, a same-cycle op still counts.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_ovf <= 1'b0;
    end else if (sticky_clr) begin
      sticky_ovf <= accept & any_ovf_n;
    end else if (accept) begin
      sticky_ovf <= sticky_ovf | any_ovf_n;
    end
  end

  assign lane_balance = lane_res[0] + lane_res[1];

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R7
  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res0) && $stable(out_res1) && $stable(out_ovf)); // R8
  AST_BFLY_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dual_n |-> lane_balance == {prod[ACCW-2:0], 1'b0}); // R4
  AST_SINGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_dual |-> out_res1 == '0 && !out_ovf1 && !out_carry1); // R4
  AST_MUL_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == FMB_OP_MUL |=> !out_carry && !out_ovf); // R5
  AST_FRAC_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_frac && op == FMB_OP_MUL |=> !out_res0[0]); // R2
  AST_UNSIGNED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_signed && op == FMB_OP_MUL |=> out_res0[ACCW-1:PRODW+1] == '0); // R1
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_ovf && !sticky_clr |=> sticky_ovf); // R6
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    accept && any_ovf_n |=> sticky_ovf); // R6
endmodule

// File: tb/fmb_butterfly_tb.sv
module fmb_butterfly_tb;
  localparam int OPW  = 20;
  localparam int ACCW = 48;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [1:0]      in_op = 2'b00;
  logic            in_signed = 1'b0;
  logic            in_frac = 1'b0;
  logic [OPW-1:0]  in_x = '0;
  logic [OPW-1:0]  in_y = '0;
  logic [ACCW-1:0] in_acc = '0;
  logic            sticky_clr = 1'b0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [ACCW-1:0] out_res0;
  logic [ACCW-1:0] out_res1;
  logic            out_dual, out_zero, out_neg, out_carry, out_ovf;
  logic            out_carry1, out_ovf1, sticky_ovf;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit exp_sticky = 1'b0;

  always #10 clk = ~clk;

  fmb_butterfly #(.OPW(OPW), .ACCW(ACCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_signed(in_signed), .in_frac(in_frac),
    .in_x(in_x), .in_y(in_y), .in_acc(in_acc), .sticky_clr(sticky_clr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_res0(out_res0), .out_res1(out_res1), .out_dual(out_dual),
    .out_zero(out_zero), .out_neg(out_neg), .out_carry(out_carry),
    .out_ovf(out_ovf), .out_carry1(out_carry1), .out_ovf1(out_ovf1),
    .sticky_ovf(sticky_ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected results computed from the arithmetic rules.
  typedef struct {
    logic [47:0] r0, r1;
    bit dual, z, n, c, v, c1, v1;
  } exp_t;

  function automatic exp_t model(input logic [1:0] op, input bit sg, input bit fr,
                                 input logic [19:0] x, input logic [19:0] y, input logic [47:0] a);
    exp_t e;
    logic [63:0] px, py, pp;
    logic [47:0] p;
    logic [48:0] s, d;
    bit vs, vd;
    px = sg ? {{44{x[19]}}, x} : {44'b0, x};
    py = sg ? {{44{y[19]}}, y} : {44'b0, y};
    pp = px * py;
    p  = pp[47:0];
    if (fr) p = {p[46:0], 1'b0};
    s  = {1'b0, p} + {1'b0, a};
    d  = {1'b0, p} + {1'b0, ~a} + 49'd1;
    vs = (p[47] == a[47]) && (s[47] != p[47]);
    vd = (p[47] != a[47]) && (d[47] != p[47]);
    e.dual = (op == 2'b11);
    case (op)
      2'b00:   begin e.r0 = p;        e.c = 1'b0; e.v = 1'b0; end
      2'b10:   begin e.r0 = d[47:0];  e.c = d[48]; e.v = vd;  end
      default: begin e.r0 = s[47:0];  e.c = s[48]; e.v = vs;  end
    endcase
    e.r1 = e.dual ? d[47:0] : 48'd0;
    e.c1 = e.dual ? d[48] : 1'b0;
    e.v1 = e.dual ? vd : 1'b0;
    e.z  = (e.r0 == 48'd0);
    e.n  = e.r0[47];
    return e;
  endfunction

  task automatic check_out(input exp_t e, input logic [1:0] op, input bit fr);
    string rq;
    rq = (op == 2'b00) ? (fr ? "R2" : "R1") : (op == 2'b11 ? "R4" : "R3");
    chk(out_valid === 1'b1, "R7 valid", {63'd0, out_valid}, 64'd1);
    chk(out_res0 === e.r0, rq, {16'd0, out_res0}, {16'd0, e.r0});
    chk(out_res1 === e.r1 && out_dual === e.dual, "R4 res1", {15'd0, out_dual, out_res1}, {15'd0, e.dual, e.r1});
    chk({out_zero, out_neg, out_carry, out_ovf, out_carry1, out_ovf1} === {e.z, e.n, e.c, e.v, e.c1, e.v1},
        "R5 flags", {58'd0, out_zero, out_neg, out_carry, out_ovf, out_carry1, out_ovf1},
        {58'd0, e.z, e.n, e.c, e.v, e.c1, e.v1});
    chk(sticky_ovf === exp_sticky, "R6 sticky", {63'd0, sticky_ovf}, {63'd0, exp_sticky});
  endtask

  task automatic do_op(input logic [1:0] op, input bit sg, input bit fr, input logic [19:0] x,
                       input logic [19:0] y, input logic [47:0] a, input bit clr);
    exp_t e;
    e = model(op, sg, fr, x, y, a);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_signed = sg; in_frac = fr;
    in_x = x; in_y = y; in_acc = a; sticky_clr = clr; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sticky_clr = 1'b0;
    exp_sticky = clr ? (e.v | e.v1) : (exp_sticky | e.v | e.v1);
    check_out(e, op, fr);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [19:0] xs [6];
  logic [47:0] as [4];

  initial begin
    exp_t ea, eb;
    int n;
    xs[0] = 20'h00000; xs[1] = 20'h00001; xs[2] = 20'hFFFFF;
    xs[3] = 20'h7FFFF; xs[4] = 20'h80000; xs[5] = 20'h1A2B3;
    as[0] = 48'h0;               as[1] = 48'h7FFF_FFFF_FFFF;
    as[2] = 48'h8000_0000_0000;  as[3] = 48'hFFFF_FFFF_FFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid === 1'b0 && sticky_ovf === 1'b0, "R9 flags", {62'd0, out_valid, sticky_ovf}, 64'd0);
    chk(out_res0 === '0 && out_res1 === '0, "R9 results", {16'd0, out_res0}, 64'd0);
    chk(in_ready === 1'b1, "R9 ready", {63'd0, in_ready}, 64'd1);

    // Sweep over ops, sign modes, fractional mode, corner operands and addends.
    n = 0;
    for (int ai = 0; ai < 4; ai++)
      for (int op = 0; op < 4; op++)
        for (int sg = 0; sg < 2; sg++)
          for (int fr = 0; fr < 2; fr++)
            for (int xi = 0; xi < 6; xi++)
              for (int yi = 0; yi < 6; yi++) begin
                do_op(2'(op), sg[0], fr[0], xs[xi], xs[yi], as[ai], (n % 37) == 0);
                n++;
              end

    // R6 idle clear: clear without an op drops sticky
    do_op(2'b01, 1'b0, 1'b0, 20'hFFFFF, 20'hFFFFF, 48'h7FFF_FFFF_FFFF, 1'b0);
    chk(sticky_ovf === 1'b1, "R6 set", {63'd0, sticky_ovf}, 64'd1);
    @(negedge clk); sticky_clr = 1'b1;
    @(negedge clk); sticky_clr = 1'b0; exp_sticky = 1'b0;
    chk(sticky_ovf === 1'b0, "R6 clear", {63'd0, sticky_ovf}, 64'd0);
    // R6 same-cycle clear with overflowing op keeps that op's overflow
    do_op(2'b11, 1'b1, 1'b0, 20'h7FFFF, 20'h7FFFF, 48'h8000_0000_0000, 1'b1);
    do_op(2'b00, 1'b1, 1'b0, 20'h00001, 20'h00001, 48'h0, 1'b1);
    chk(sticky_ovf === 1'b0, "R6 clear with quiet op", {63'd0, sticky_ovf}, 64'd0);

    // R8 back-pressure
    ea = model(2'b01, 1'b1, 1'b1, 20'h00123, 20'hFFFFE, 48'h10);
    eb = model(2'b11, 1'b0, 1'b0, 20'h00456, 20'h00002, 48'h5);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_op = 2'b01; in_signed = 1'b1; in_frac = 1'b1;
    in_x = 20'h00123; in_y = 20'hFFFFE; in_acc = 48'h10;
    @(negedge clk);
    chk(out_valid === 1'b1 && out_res0 === ea.r0, "R7 first result", {16'd0, out_res0}, {16'd0, ea.r0});
    in_op = 2'b11; in_signed = 1'b0; in_frac = 1'b0; in_x = 20'h00456; in_y = 20'h00002; in_acc = 48'h5;
    chk(in_ready === 1'b0, "R8 stall ready", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    chk(out_res0 === ea.r0 && out_dual === 1'b0, "R8 hold", {16'd0, out_res0}, {16'd0, ea.r0});
    chk(in_ready === 1'b0, "R8 still stalled", {63'd0, in_ready}, 64'd0);
    out_ready = 1'b1;
    #1;
    chk(in_ready === 1'b1, "R8 ready follows drain", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && out_res0 === eb.r0 && out_res1 === eb.r1, "R8 pass-through",
        {16'd0, out_res1}, {16'd0, eb.r1});
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 drain", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule